// File: doc/BRIEF.md
# Decaying Load-Delay Curve Trainer

This block keeps a table of load-delay curves, one entry per curve and load index, and refines them with latency samples taken from a detailed reference model that runs alongside a fast latency estimator. Each accepted sample names a curve, a load index, the latency the reference model measured, and the latency the estimator had predicted. The block reads the addressed entry, moves it toward the measured latency with a decaying average of factor `DECAY`, and writes it back. Only the addressed entry changes. Entries are preloaded with offline-trained values before training starts.

A scheduler repeats three phases. The estimator runs free for a quantum. The reference model then warms up for a fixed number of cycles, and no update is made during that time. Training windows follow. During each window the block sums the predicted and the measured latencies. At the end of a window, a relative error below 5% returns the block to free running. Otherwise a new window starts with cleared sums. A mode input selects a second, more aggressive schedule with a longer quantum and a shorter window.

The sample input is a valid/ready stream. `smp_ready` is held high, so a sample is taken in every cycle that `smp_valid` is high. No back-pressure is applied, and a sample taken outside a training window is dropped.

Top module: `curve_trainer`

## Requirements
- R1: After reset, `phase` reads 0 (free running) and every curve entry reads 0.
- R2: In standard mode (`sched_aggr`=0), free running lasts `QUANT_STD` cycles, warm-up (`phase`=1) lasts `WARM_LEN` cycles, and each training window (`phase`=2) lasts `TRAIN_STD` cycles. The phases always follow the order 0, 1, 2.
- R3: With `sched_aggr`=1, free running lasts `QUANT_AGG` cycles and a training window lasts `TRAIN_AGG` cycles. Warm-up length does not change.
- R4: An accepted sample with measured latency L (an integer) sets the entry E, an unsigned fixed-point value with 8 fractional bits, to floor((E×(DECAY−1) + L×256) / DECAY).
- R5: A sample changes only the entry at its own curve and load index.
- R6: Two samples to the same entry in consecutive cycles both take effect in order: the second sample blends into the result of the first.
- R7: A sample presented while `phase` is not 2 changes no entry and does not count toward the window error.
- R8: Let Se and Sa be the window sums of predicted and measured latency. At the end of a window, the block returns to `phase` 0 when |Se−Sa|×100 < 5×Sa. Otherwise it starts another window. Equality counts as a failure.
- R9: A preload write (`pre_we`) sets the addressed entry to `pre_data` when `phase` is not 2, and is ignored when `phase` is 2. If a preload and a pending update hit the same entry in the same cycle, the update wins.
- R10: `smp_ready` is high in every cycle after reset.
- R11: `rd_data` returns the entry addressed by `rd_curve`/`rd_load` in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sched_aggr | input | 1 | Selects the aggressive schedule |
| smp_valid | input | 1 | Sample valid |
| smp_ready | output | 1 | Sample ready (held high) |
| smp_curve | input | CSEL_W | Curve selector of the sample |
| smp_load | input | LIDX_W | Load index of the sample |
| smp_act | input | LAT_W | Latency measured by the reference model |
| smp_est | input | LAT_W | Latency predicted by the estimator |
| pre_we | input | 1 | Preload write enable |
| pre_curve | input | CSEL_W | Preload curve selector |
| pre_load | input | LIDX_W | Preload load index |
| pre_data | input | ENTRY_W | Preload value, 8 fractional bits |
| rd_curve | input | CSEL_W | Read curve selector |
| rd_load | input | LIDX_W | Read load index |
| rd_data | output | ENTRY_W | Entry read one cycle after the address |
| phase | output | 2 | 0 free running, 1 warm-up, 2 training |

## Verification
The decay update is driven with samples both below and above the stored entry, on several curves, and with two back-to-back samples to one entry. These cases separate truncation from rounding, show that only the addressed entry changes, and detect a stale read in the read-modify-write loop. The window test uses a window with zero error, one whose error is exactly 5% (it must fail), and one just under 5% (it must pass). The phase durations that result show whether the comparison is strict. Samples and preloads placed in free running, warm-up and training separate the gating of updates from the gating of the error sums. A period run with the mode input set shows which schedule limits are in use.

// File: rtl/ctrn_pkg.sv
package ctrn_pkg;
  typedef enum logic [1:0] {
    PH_RUN   = 2'd0,
    PH_WARM  = 2'd1,
    PH_TRAIN = 2'd2
  } phase_e;
endpackage

// File: rtl/ctrn_blend.sv
// Decaying average of a stored fixed-point entry and an integer latency sample.
module ctrn_blend #(
  parameter int ENTRY_W = 16,
  parameter int LAT_W   = 8,
  parameter int FRAC    = 8,
  parameter int DECAY   = 100
) (
  input  logic [ENTRY_W-1:0] old_val,
  input  logic [LAT_W-1:0]   lat,
  output logic [ENTRY_W-1:0] new_val
);
  localparam int PROD_W = ENTRY_W + $clog2(DECAY) + 1;

  logic [PROD_W-1:0] num;
  logic [PROD_W-1:0] quo;

  always_comb begin
    num = PROD_W'(old_val) * PROD_W'(DECAY - 1) + (PROD_W'(lat) << FRAC);
    quo = num / PROD_W'(DECAY);
    new_val = quo[ENTRY_W-1:0];
  end
endmodule

// File: rtl/ctrn_store.sv
// Curve storage with a two-stage read-modify-write path and same-entry forwarding.
module ctrn_store #(
  parameter int NUM_CURVES = 4,
  parameter int NUM_LOADS  = 32,
  parameter int ENTRY_W    = 16,
  parameter int LAT_W      = 8,
  parameter int FRAC       = 8,
  parameter int DECAY      = 100,
  localparam int CSEL_W    = $clog2(NUM_CURVES),
  localparam int LIDX_W    = $clog2(NUM_LOADS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_go,
  input  logic [CSEL_W-1:0]  upd_curve,
  input  logic [LIDX_W-1:0]  upd_load,
  input  logic [LAT_W-1:0]   upd_lat,
  input  logic               pre_ok,
  input  logic [CSEL_W-1:0]  pre_curve,
  input  logic [LIDX_W-1:0]  pre_load,
  input  logic [ENTRY_W-1:0] pre_data,
  input  logic [CSEL_W-1:0]  rd_curve,
  input  logic [LIDX_W-1:0]  rd_load,
  output logic [ENTRY_W-1:0] rd_data
);
  localparam int DEPTH = NUM_CURVES * NUM_LOADS;
  localparam int AW    = $clog2(DEPTH);

  logic [ENTRY_W-1:0] mem [DEPTH];

  logic [AW-1:0]      s_addr, pre_addr, rd_addr;
  logic [ENTRY_W-1:0] s_old;

  logic               p_vld;
  logic [AW-1:0]      p_addr;
  logic [ENTRY_W-1:0] p_old;
  logic [LAT_W-1:0]   p_lat;
  logic [ENTRY_W-1:0] p_new;
  logic [ENTRY_W-1:0] p_smp;

  always_comb begin
    s_addr   = AW'(upd_curve) * AW'(NUM_LOADS) + AW'(upd_load);
    pre_addr = AW'(pre_curve) * AW'(NUM_LOADS) + AW'(pre_load);
    rd_addr  = AW'(rd_curve) * AW'(NUM_LOADS) + AW'(rd_load);
    // Forward the result still in flight when the same entry is hit again.
    s_old = (p_vld && (p_addr == s_addr)) ? p_new : mem[s_addr];
    p_smp = ENTRY_W'(p_lat) << FRAC;
  end

  ctrn_blend #(
    .ENTRY_W(ENTRY_W), .LAT_W(LAT_W), .FRAC(FRAC), .DECAY(DECAY)
  ) u_blend (
    .old_val(p_old),
    .lat    (p_lat),
    .new_val(p_new)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_vld  <= 1'b0;
      p_addr <= '0;
      p_old  <= '0;
      p_lat  <= '0;
    end else begin
      p_vld <= upd_go;
      if (upd_go) begin
        p_addr <= s_addr;
        p_old  <= s_old;
        p_lat  <= upd_lat;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rd_data <= '0;
    end else begin
      if (pre_ok) mem[pre_addr] <= pre_data;
      if (p_vld)  mem[p_addr]   <= p_new;   // update has priority over preload
      rd_data <= mem[rd_addr];
    end
  end

  // R4: a blended entry lies between the old entry and the scaled sample
  a_r4_blend_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    p_vld |-> ((p_new <= ((p_old > p_smp) ? p_old : p_smp)) &&
               (p_new >= ((p_old < p_smp) ? p_old : p_smp))));

  // R6: a back-to-back hit on one entry starts from the in-flight result
  a_r6_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (p_vld && upd_go && (p_addr == s_addr)) |=> (p_old == $past(p_new)));
endmodule

// File: rtl/ctrn_judge.sv
// Window error accumulation and the threshold test without a divider.
module ctrn_judge #(
  parameter int LAT_W = 8,
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_train,
  input  logic             take,
  input  logic [LAT_W-1:0] est,
  input  logic [LAT_W-1:0] act,
  input  logic             win_last,
  output logic             win_pass
);
  localparam int CMP_W = ACC_W + 7;

  logic [ACC_W-1:0] acc_est, acc_act;
  logic [ACC_W-1:0] nxt_est, nxt_act;
  logic [ACC_W-1:0] diff;

  always_comb begin
    nxt_est  = acc_est + (take ? ACC_W'(est) : '0);
    nxt_act  = acc_act + (take ? ACC_W'(act) : '0);
    diff     = (nxt_est > nxt_act) ? (nxt_est - nxt_act) : (nxt_act - nxt_est);
    win_pass = (CMP_W'(diff) * CMP_W'(100)) < (CMP_W'(nxt_act) * CMP_W'(5));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_est <= '0;
      acc_act <= '0;
    end else if (!in_train || win_last) begin
      acc_est <= '0;
      acc_act <= '0;
    end else begin
      acc_est <= nxt_est;
      acc_act <= nxt_act;
    end
  end

  // R8: sums only grow inside a window
  a_r8_acc_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (in_train && !win_last) |=> ((acc_act >= $past(acc_act)) && (acc_est >= $past(acc_est))));
endmodule

// File: rtl/ctrn_sched.sv
// Phase sequencer: free run, warm-up, training windows.
module ctrn_sched
  import ctrn_pkg::*;
#(
  parameter int QUANT_STD = 100000,
  parameter int QUANT_AGG = 500000,
  parameter int WARM_LEN  = 1000,
  parameter int TRAIN_STD = 10000,
  parameter int TRAIN_AGG = 5000
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   aggr,
  input  logic   win_pass,
  output phase_e phase,
  output logic   win_last
);
  localparam int MQ    = (QUANT_STD > QUANT_AGG) ? QUANT_STD : QUANT_AGG;
  localparam int MT    = (TRAIN_STD > TRAIN_AGG) ? TRAIN_STD : TRAIN_AGG;
  localparam int MW    = (MT > WARM_LEN) ? MT : WARM_LEN;
  localparam int MAXL  = (MQ > MW) ? MQ : MW;
  localparam int CNT_W = $clog2(MAXL + 1);

  logic [CNT_W-1:0] cnt, limit;
  logic             last;

  always_comb begin
    unique case (phase)
      PH_RUN:   limit = aggr ? CNT_W'(QUANT_AGG) : CNT_W'(QUANT_STD);
      PH_WARM:  limit = CNT_W'(WARM_LEN);
      default:  limit = aggr ? CNT_W'(TRAIN_AGG) : CNT_W'(TRAIN_STD);
    endcase
    // >= keeps a mode switch to a shorter limit from overrunning
    last     = (cnt >= (limit - CNT_W'(1)));
    win_last = (phase == PH_TRAIN) && last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_RUN;
      cnt   <= '0;
    end else begin
      cnt <= last ? '0 : cnt + CNT_W'(1);
      if (last) begin
        unique case (phase)
          PH_RUN:  phase <= PH_WARM;
          PH_WARM: phase <= PH_TRAIN;
          default: phase <= win_pass ? PH_RUN : PH_TRAIN;
        endcase
      end
    end
  end

  // R2: phase order
  a_r2_run_next: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUN) |=> (phase == PH_RUN || phase == PH_WARM));
  a_r2_warm_next: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WARM) |=> (phase == PH_WARM || phase == PH_TRAIN));
  a_r2_train_next: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TRAIN) |=> (phase == PH_TRAIN || phase == PH_RUN));
  // R8: a failed window keeps training
  a_r8_retry: assert property (@(posedge clk) disable iff (!rst_n)
    (win_last && !win_pass) |=> (phase == PH_TRAIN));
endmodule

// File: rtl/curve_trainer.sv
module curve_trainer
  import ctrn_pkg::*;
#(
  parameter int NUM_CURVES = 4,
  parameter int NUM_LOADS  = 32,
  parameter int ENTRY_W    = 16,
  parameter int LAT_W      = 8,
  parameter int FRAC       = 8,
  parameter int DECAY      = 100,
  parameter int ACC_W      = 32,
  parameter int QUANT_STD  = 100000,
  parameter int QUANT_AGG  = 500000,
  parameter int WARM_LEN   = 1000,
  parameter int TRAIN_STD  = 10000,
  parameter int TRAIN_AGG  = 5000,
  localparam int CSEL_W    = $clog2(NUM_CURVES),
  localparam int LIDX_W    = $clog2(NUM_LOADS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sched_aggr,
  input  logic               smp_valid,
  output logic               smp_ready,
  input  logic [CSEL_W-1:0]  smp_curve,
  input  logic [LIDX_W-1:0]  smp_load,
  input  logic [LAT_W-1:0]   smp_act,
  input  logic [LAT_W-1:0]   smp_est,
  input  logic               pre_we,
  input  logic [CSEL_W-1:0]  pre_curve,
  input  logic [LIDX_W-1:0]  pre_load,
  input  logic [ENTRY_W-1:0] pre_data,
  input  logic [CSEL_W-1:0]  rd_curve,
  input  logic [LIDX_W-1:0]  rd_load,
  output logic [ENTRY_W-1:0] rd_data,
  output logic [1:0]         phase
);
  phase_e ph;
  logic   in_train, take, pre_ok, win_last, win_pass;

  always_comb begin
    smp_ready = 1'b1;
    in_train  = (ph == PH_TRAIN);
    take      = smp_valid && in_train;
    pre_ok    = pre_we && !in_train;
    phase     = ph;
  end

  ctrn_sched #(
    .QUANT_STD(QUANT_STD), .QUANT_AGG(QUANT_AGG), .WARM_LEN(WARM_LEN),
    .TRAIN_STD(TRAIN_STD), .TRAIN_AGG(TRAIN_AGG)
  ) u_sched (
    .clk(clk), .rst_n(rst_n), .aggr(sched_aggr), .win_pass(win_pass),
    .phase(ph), .win_last(win_last)
  );

  ctrn_judge #(.LAT_W(LAT_W), .ACC_W(ACC_W)) u_judge (
    .clk(clk), .rst_n(rst_n), .in_train(in_train), .take(take),
    .est(smp_est), .act(smp_act), .win_last(win_last), .win_pass(win_pass)
  );

  ctrn_store #(
    .NUM_CURVES(NUM_CURVES), .NUM_LOADS(NUM_LOADS), .ENTRY_W(ENTRY_W),
    .LAT_W(LAT_W), .FRAC(FRAC), .DECAY(DECAY)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .upd_go(take), .upd_curve(smp_curve), .upd_load(smp_load), .upd_lat(smp_act),
    .pre_ok(pre_ok), .pre_curve(pre_curve), .pre_load(pre_load), .pre_data(pre_data),
    .rd_curve(rd_curve), .rd_load(rd_load), .rd_data(rd_data)
  );
endmodule

// File: tb/tb_curve_trainer.sv
module tb_curve_trainer;
  localparam int QS = 40, QA = 60, WL = 8, TS = 16, TA = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        sched_aggr = 0;
  logic        smp_valid = 0;
  logic        smp_ready;
  logic [1:0]  smp_curve = 0;
  logic [4:0]  smp_load = 0;
  logic [7:0]  smp_act = 0, smp_est = 0;
  logic        pre_we = 0;
  logic [1:0]  pre_curve = 0;
  logic [4:0]  pre_load = 0;
  logic [15:0] pre_data = 0;
  logic [1:0]  rd_curve = 0;
  logic [4:0]  rd_load = 0;
  logic [15:0] rd_data;
  logic [1:0]  phase;

  always #2.5 clk = ~clk;

  curve_trainer #(
    .QUANT_STD(QS), .QUANT_AGG(QA), .WARM_LEN(WL), .TRAIN_STD(TS), .TRAIN_AGG(TA)
  ) dut (
    .clk(clk), .rst_n(rst_n), .sched_aggr(sched_aggr),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_curve(smp_curve),
    .smp_load(smp_load), .smp_act(smp_act), .smp_est(smp_est),
    .pre_we(pre_we), .pre_curve(pre_curve), .pre_load(pre_load), .pre_data(pre_data),
    .rd_curve(rd_curve), .rd_load(rd_load), .rd_data(rd_data), .phase(phase)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int model [4][32];

  typedef struct { int due; int exp; string tag; } rd_item_t;
  rd_item_t rdq[$];

  function automatic int blend(int old, int lat);
    return (old * 99 + lat * 256) / 100;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // monitor: compares read results against the scoreboard queue
  always @(negedge clk) begin
    while (rdq.size() > 0 && rdq[0].due == cyc) begin
      rd_item_t it;
      it = rdq.pop_front();
      check(int'(rd_data) == it.exp, it.tag, int'(rd_data), it.exp);
    end
  end

  task automatic rd(int c, int l, string tag);
    rd_item_t it;
    @(negedge clk);
    rd_curve = 2'(c); rd_load = 5'(l);
    it.due = cyc + 1; it.exp = model[c][l]; it.tag = tag;
    rdq.push_back(it);
  endtask

  task automatic sample(int c, int l, int act, int est);
    @(negedge clk);
    smp_valid = 1; smp_curve = 2'(c); smp_load = 5'(l);
    smp_act = 8'(act); smp_est = 8'(est);
    if (phase == 2'd2) model[c][l] = blend(model[c][l], act);
  endtask

  task automatic idle();
    @(negedge clk);
    smp_valid = 0;
  endtask

  task automatic pre(int c, int l, int d);
    @(negedge clk);
    pre_we = 1; pre_curve = 2'(c); pre_load = 5'(l); pre_data = 16'(d);
    if (phase != 2'd2) model[c][l] = d;
    @(negedge clk);
    pre_we = 0;
  endtask

  task automatic wait_phase(logic [1:0] p, output int t);
    do @(negedge clk); while (phase != p);
    t = cyc;
  endtask

  task automatic wait_until(int target);
    while (cyc < target) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    int t_w, t_t, t_r1, t_w2, t_t2, t_r2, t_w3, t_t3, t_r3;
    foreach (model[i, j]) model[i][j] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(phase == 2'd0, "R1 phase", phase, 0);
    rd(0, 3, "R1 entry"); rd(3, 31, "R1 entry");
    // R9 preload outside training
    pre(0, 3, 16'h1000); pre(1, 5, 16'h0A00); pre(2, 3, 16'h2000);
    // R7 sample during free run is dropped
    sample(0, 3, 200, 0); idle();
    rd(0, 3, "R7 run sample ignored / R9 preload");
    rd(1, 5, "R9 preload");
    wait_phase(2'd1, t_w);
    check(smp_ready == 1'b1, "R10 ready", smp_ready, 1);
    // R7 warm-up sample: no update and no error contribution
    sample(1, 5, 1, 255); idle();
    pre(2, 7, 16'h0500);
    wait_phase(2'd2, t_t);
    check(t_t - t_w == WL, "R2 warm length", t_t - t_w, WL);
    // R4, R6: back-to-back on one entry, then another curve
    sample(0, 3, 20, 20);
    sample(0, 3, 200, 200);
    sample(1, 5, 7, 7);
    idle();
    pre(1, 6, 16'h3333);   // R9 ignored in training
    wait_phase(2'd0, t_r1);
    check(t_r1 - t_t == TS, "R2 R8 window length, zero error exits", t_r1 - t_t, TS);
    rd(0, 3, "R4 R6 decayed entry");
    rd(1, 5, "R4 R7 decayed entry");
    rd(2, 3, "R5 neighbour untouched");
    rd(1, 6, "R9 preload in training ignored");
    rd(2, 7, "R9 preload in warm-up");
    check(smp_ready == 1'b1, "R10 ready", smp_ready, 1);
    wait_phase(2'd1, t_w2);
    check(t_w2 - t_r1 == QS, "R2 quantum", t_w2 - t_r1, QS);
    wait_phase(2'd2, t_t2);
    // R8 exactly 5% error fails, then 4% passes
    sample(3, 0, 100, 105); idle();
    wait_until(t_t2 + TS + 1);
    sample(3, 0, 100, 104); idle();
    wait_phase(2'd0, t_r2);
    check(t_r2 - t_t2 == 2 * TS, "R8 boundary window retried", t_r2 - t_t2, 2 * TS);
    sched_aggr = 1;
    rd(3, 0, "R4 two windows");
    wait_phase(2'd1, t_w3);
    check(t_w3 - t_r2 == QA, "R3 aggressive quantum", t_w3 - t_r2, QA);
    wait_phase(2'd2, t_t3);
    check(t_t3 - t_w3 == WL, "R3 warm unchanged", t_t3 - t_w3, WL);
    sample(0, 4, 50, 50); idle();
    wait_phase(2'd0, t_r3);
    check(t_r3 - t_t3 == TA, "R3 aggressive window", t_r3 - t_t3, TA);
    rd(0, 4, "R4 R11 aggressive update");
    rd(0, 3, "R5 entry unchanged");
    repeat (4) @(negedge clk);
    check(rdq.size() == 0, "R11 reads drained", rdq.size(), 0);
    finish_run();
  end
endmodule